// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, cycle by cycle, which pipeline registers of an in-order five-stage core may load. It looks at the decoded class and register fields of the instruction in decode and the instruction in execute. It holds fetch and decode when a dependency cannot be covered by forwarding. In that cycle it turns the instruction entering execute into a no-op. It also freezes every stage while a multi-cycle multiply or divide sits in execute, and it emits a one-cycle launch strobe for that unit.

The write enables come out as one active-high vector with one bit per pipeline register. Each bit is the inverse of that stage's stall. The enables and the bubble are combinational functions of the present inputs and one bit of multiply/divide state. The launch strobe depends on that state bit, which records that an operation has already been launched.

Instruction class encoding on `xKind` and `dKind`: 0 other, 1 ALU, 2 load, 3 store, 4 jump-register. Enable bit positions on `stageWe`: bit 0 program counter, bit 1 fetch/decode, bit 2 decode/execute, bit 3 execute/memory, bit 4 memory/writeback.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: With a load in execute whose destination `xRd` is non-zero, an ALU instruction in decode that reads that register stalls the front end. The ALU instruction reads it through `dRegA`, or through `dRegB` when `dUseB` is 1. The stall gives `stageWe` = 5'b11100 and `dxBubble` = 1.
- R2: An ALU instruction whose `dRegB` matches the load destination does not stall when `dUseB` is 0 (`stageWe` = 5'b11111, `dxBubble` = 0).
- R3: A load in execute followed by a jump-register in decode whose target `dRegA` equals `xRd` stalls as in R1. A different target does not stall.
- R4: A store in execute followed by a store in decode whose base `dRegA` equals the first store's register `xRd` stalls as in R1. A match only on the second store's `dRegB` does not stall.
- R5: When `xRd` is 0, no pairing produces a stall.
- R6: Pairings other than load→ALU, load→jump-register and store→store never stall. Examples are load→store, load→load, ALU→ALU and store→jump-register.
- R7: While `xIsMulDiv` is 1 and `mdReady` is 0, all five enables are 0 and `dxBubble` is 0.
- R8: In a cycle where `xIsMulDiv` and `mdReady` are both 1, all five enables are 1, so the result advances exactly once.
- R9: `mdStart` is 1 only in the first cycle that a multiply/divide occupies execute. It stays 0 for the rest of that operation, and it rises again for the next operation after a ready cycle.
- R10: Reset clears the launch state. After reset, idle inputs give all enables 1, `dxBubble` 0 and `mdStart` 0, and a multiply/divide present after reset launches at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xKind | input | 3 | Class of the execute instruction |
| xRd | input | 5 | Load destination or store data register in execute |
| xIsMulDiv | input | 1 | Execute holds a multiply or divide |
| mdReady | input | 1 | Multiply/divide result valid this cycle |
| dKind | input | 3 | Class of the decode instruction |
| dRegA | input | 5 | First source: ALU operand, jump target or store base |
| dRegB | input | 5 | Second source register of decode |
| dUseB | input | 1 | ALU in decode reads `dRegB` |
| stageWe | output | 5 | Pipeline register write enables |
| dxBubble | output | 1 | Load a no-op into decode/execute |
| mdStart | output | 1 | Launch strobe for the multiply/divide unit |

## Verification
The enables and the bubble follow the inputs in the same cycle. The bench therefore drives each vector on the falling edge and compares it one nanosecond later, before the next rising edge. The launch strobe also settles in the same cycle, but its value depends on the state captured at the previous rising edge. The multiply/divide sequence therefore walks one falling edge per step and predicts the strobe from the number of rising edges since the operation entered execute or since reset.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int REG_W    = 5;
  localparam int KIND_W   = 3;
  localparam int NUM_STG  = 5;
  localparam int NUM_SRC  = 2;

  // stage index into the enable vector; order follows the pipeline
  localparam int STG_PC = 0;
  localparam int STG_FD = 1;
  localparam int STG_DX = 2;
  localparam int STG_XM = 3;
  localparam int STG_MW = 4;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER = 3'd0,
    K_ALU   = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_JR    = 3'd4
  } kind_e;

  // strobes from the multiply/divide control to the enable datapath
  typedef struct packed {
    logic freeze;
    logic mdStart;
  } ctrl_t;
endpackage

// File: rtl/hsc_src_match.sv
module hsc_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcReg,
  input  logic             srcUsed,
  input  logic [REG_W-1:0] dstReg,
  output logic             hit
);
  // register zero is never a real producer
  always_comb hit = srcUsed && (srcReg == dstReg) && (dstReg != '0);
endmodule

// File: rtl/hsc_md_ctrl.sv
module hsc_md_ctrl
  import hsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  xIsMulDiv,
  input  logic  mdReady,
  output ctrl_t ctrl
);
  typedef enum logic {MD_IDLE, MD_RUN} md_state_e;
  md_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (!xIsMulDiv || mdReady) stateNext = MD_IDLE;
    else                       stateNext = MD_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= MD_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctrl.freeze  = xIsMulDiv && !mdReady;
    ctrl.mdStart = xIsMulDiv && (state == MD_IDLE);
  end

  // R9: an operation that is still running never launches twice
  a_r9_single_launch: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mdStart && !mdReady) |=> !ctrl.mdStart);
  // R9: after a ready cycle a present operation launches again
  a_r9_relaunch: assert property (@(posedge clk) disable iff (rst)
    (mdReady && xIsMulDiv) |=> (xIsMulDiv -> ctrl.mdStart));
endmodule

// File: rtl/hsc_hazard_dp.sv
module hsc_hazard_dp
  import hsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [KIND_W-1:0]  xKind,
  input  logic [REG_W-1:0]   xRd,
  input  logic [KIND_W-1:0]  dKind,
  input  logic [REG_W-1:0]   dRegA,
  input  logic [REG_W-1:0]   dRegB,
  input  logic               dUseB,
  input  ctrl_t              ctrl,
  output logic [NUM_STG-1:0] stageWe,
  output logic               dxBubble
);
  kind_e xK, dK;
  always_comb begin
    xK = kind_e'(xKind);
    dK = kind_e'(dKind);
  end

  logic [REG_W-1:0]   srcReg  [NUM_SRC];
  logic [NUM_SRC-1:0] srcUsed;
  logic [NUM_SRC-1:0] srcHit;

  always_comb begin
    srcReg[0]  = dRegA;
    srcReg[1]  = dRegB;
    srcUsed[0] = (dK == K_ALU) || (dK == K_JR) || (dK == K_STORE);
    srcUsed[1] = (dK == K_ALU) && dUseB;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hsc_src_match #(.REG_W(REG_W)) u_match (
      .srcReg (srcReg[s]),
      .srcUsed(srcUsed[s]),
      .dstReg (xRd),
      .hit    (srcHit[s])
    );
  end

  logic loadUse, loadJr, storeBase, hazard;
  always_comb begin
    loadUse   = (xK == K_LOAD)  && (dK == K_ALU)   && (|srcHit);
    loadJr    = (xK == K_LOAD)  && (dK == K_JR)    && srcHit[0];
    storeBase = (xK == K_STORE) && (dK == K_STORE) && srcHit[0];
    hazard    = loadUse || loadJr || storeBase;
  end

  // freeze dominates; a hazard holds only the stages ahead of execute
  for (genvar g = 0; g < NUM_STG; g++) begin : g_we
    if (g < STG_DX) begin : g_front
      always_comb stageWe[g] = !ctrl.freeze && !hazard;
    end else begin : g_back
      always_comb stageWe[g] = !ctrl.freeze;
    end
  end

  always_comb dxBubble = hazard && !ctrl.freeze;

  // R1: a bubble always comes with a held front end and a loading execute
  a_r1_bubble_shape: assert property (@(posedge clk) disable iff (rst)
    dxBubble |-> (!stageWe[STG_PC] && !stageWe[STG_FD] && stageWe[STG_DX]
                  && stageWe[STG_XM] && stageWe[STG_MW]));
  // R5: register zero never causes a bubble
  a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (xRd == '0) |-> !dxBubble);
  // R7: a frozen pipeline loads nothing and inserts nothing
  a_r7_freeze_all: assert property (@(posedge clk) disable iff (rst)
    ctrl.freeze |-> (stageWe == '0 && !dxBubble));
  // R6: an ALU in execute never stalls the front end
  a_r6_alu_free: assert property (@(posedge clk) disable iff (rst)
    (xK == K_ALU && !ctrl.freeze) |-> (stageWe == '1));
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [KIND_W-1:0]  xKind,
  input  logic [REG_W-1:0]   xRd,
  input  logic               xIsMulDiv,
  input  logic               mdReady,
  input  logic [KIND_W-1:0]  dKind,
  input  logic [REG_W-1:0]   dRegA,
  input  logic [REG_W-1:0]   dRegB,
  input  logic               dUseB,
  output logic [NUM_STG-1:0] stageWe,
  output logic               dxBubble,
  output logic               mdStart
);
  ctrl_t ctrl;

  hsc_md_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xIsMulDiv(xIsMulDiv),
    .mdReady  (mdReady),
    .ctrl     (ctrl)
  );

  hsc_hazard_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .xKind   (xKind),
    .xRd     (xRd),
    .dKind   (dKind),
    .dRegA   (dRegA),
    .dRegB   (dRegB),
    .dUseB   (dUseB),
    .ctrl    (ctrl),
    .stageWe (stageWe),
    .dxBubble(dxBubble)
  );

  always_comb mdStart = ctrl.mdStart;

  // R8: a ready result always moves into the memory stage
  a_r8_ready_advance: assert property (@(posedge clk) disable iff (rst)
    (xIsMulDiv && mdReady) |-> (stageWe[STG_XM] && stageWe[STG_MW]));
endmodule

// File: tb/hazard_stall_ctrl_bench.sv
module hazard_stall_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] xKind = '0;
  logic [4:0] xRd = '0;
  logic       xIsMulDiv = 1'b0;
  logic       mdReady = 1'b0;
  logic [2:0] dKind = '0;
  logic [4:0] dRegA = '0;
  logic [4:0] dRegB = '0;
  logic       dUseB = 1'b0;
  logic [4:0] stageWe;
  logic       dxBubble;
  logic       mdStart;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  hazard_stall_ctrl u_hazard_stall_ctrl (
    .clk(clk), .rst(rst), .xKind(xKind), .xRd(xRd), .xIsMulDiv(xIsMulDiv),
    .mdReady(mdReady), .dKind(dKind), .dRegA(dRegA), .dRegB(dRegB),
    .dUseB(dUseB), .stageWe(stageWe), .dxBubble(dxBubble), .mdStart(mdStart)
  );

  // class codes: 0 other, 1 ALU, 2 load, 3 store, 4 jump-register
  // fields: xKind, xRd, dKind, dRegA, dRegB, dUseB, expected stageWe, expected bubble
  localparam int NV = 13;
  localparam logic [27:0] VECS [NV] = '{
    {3'd2, 5'd7, 3'd1, 5'd7, 5'd3, 1'b0, 5'b11100, 1'b1}, // R1 source A
    {3'd2, 5'd7, 3'd1, 5'd2, 5'd7, 1'b1, 5'b11100, 1'b1}, // R1 source B
    {3'd2, 5'd7, 3'd1, 5'd3, 5'd7, 1'b0, 5'b11111, 1'b0}, // R2
    {3'd2, 5'd9, 3'd4, 5'd9, 5'd0, 1'b0, 5'b11100, 1'b1}, // R3 match
    {3'd2, 5'd9, 3'd4, 5'd8, 5'd9, 1'b0, 5'b11111, 1'b0}, // R3 miss
    {3'd3, 5'd4, 3'd3, 5'd4, 5'd1, 1'b0, 5'b11100, 1'b1}, // R4 base match
    {3'd3, 5'd4, 3'd3, 5'd5, 5'd4, 1'b0, 5'b11111, 1'b0}, // R4 data only
    {3'd2, 5'd0, 3'd1, 5'd0, 5'd0, 1'b1, 5'b11111, 1'b0}, // R5 load r0
    {3'd3, 5'd0, 3'd3, 5'd0, 5'd0, 1'b0, 5'b11111, 1'b0}, // R5 store r0
    {3'd2, 5'd6, 3'd3, 5'd6, 5'd6, 1'b0, 5'b11111, 1'b0}, // R6 load->store
    {3'd1, 5'd6, 3'd1, 5'd6, 5'd6, 1'b1, 5'b11111, 1'b0}, // R6 alu->alu
    {3'd2, 5'd6, 3'd2, 5'd6, 5'd0, 1'b0, 5'b11111, 1'b0}, // R6 load->load
    {3'd3, 5'd2, 3'd4, 5'd2, 5'd0, 1'b0, 5'b11111, 1'b0}  // R6 store->jr
  };
  localparam string VTAG [NV] = '{"R1","R1","R2","R3","R3","R4","R4",
                                  "R5","R5","R6","R6","R6","R6"};

  task automatic check(input string tag, input logic [4:0] expWe,
                       input logic expBub, input logic expStart);
    nChecks++;
    if (stageWe !== expWe || dxBubble !== expBub || mdStart !== expStart) begin
      nFails++;
      $display("FAIL %s: got we=%b bub=%b start=%b, expected we=%b bub=%b start=%b",
               tag, stageWe, dxBubble, mdStart, expWe, expBub, expStart);
    end
  endtask

  task automatic step(input logic md, input logic rdy);
    @(negedge clk);
    xIsMulDiv = md;
    mdReady   = rdy;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 idle after reset", 5'b11111, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {xKind, xRd, dKind, dRegA, dRegB, dUseB} = VECS[i][27:6];
      #1;
      check(VTAG[i], VECS[i][5:1], VECS[i][0], 1'b0);
    end

    @(negedge clk);
    xKind = 3'd0; xRd = 5'd0; dKind = 3'd0; dRegA = '0; dRegB = '0; dUseB = 1'b0;

    // multiply/divide: launch, hold, ready, leave
    step(1'b1, 1'b0); check("R7 R9 launch and freeze", 5'b00000, 1'b0, 1'b1);
    step(1'b1, 1'b0); check("R9 no relaunch",          5'b00000, 1'b0, 1'b0);
    step(1'b1, 1'b0); check("R7 still frozen",         5'b00000, 1'b0, 1'b0);
    step(1'b1, 1'b1); check("R8 ready advances",       5'b11111, 1'b0, 1'b0);
    step(1'b0, 1'b0); check("R8 released",             5'b11111, 1'b0, 1'b0);
    step(1'b1, 1'b0); check("R9 next launch",          5'b00000, 1'b0, 1'b1);
    step(1'b1, 1'b1); check("R8 second ready",         5'b11111, 1'b0, 1'b0);
    // back-to-back operation directly after a ready cycle
    step(1'b1, 1'b0); check("R9 relaunch after ready", 5'b00000, 1'b0, 1'b1);

    // R10: reset in the middle of a running operation
    step(1'b1, 1'b0); check("R9 running",              5'b00000, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R10 launch after reset", 5'b00000, 1'b0, 1'b1);
    step(1'b0, 1'b0); check("R10 idle", 5'b11111, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule